// File: doc/BRIEF.md
# Latency-Modeled Multiply-Accumulate Memory Unit

This block is one compute-in-memory tile. It has a weight store, a small scratch buffer and one signed multiply-accumulate element. A host loads weights into the store and an input vector into the low part of the buffer. It then issues a job. For each output channel, the tile copies that channel's weights into a staging area of the buffer, streams input and weight pairs through the multiply-accumulate element, and writes the accumulated result to an output area of the buffer. The host reads results back through the same buffer port.

Every access is stretched to a whole number of clock cycles, so the tile behaves like a memory with real device latency. A single parameter selects the fast or the slow device timing. The cycle counts are derived from device latencies in picoseconds: each latency is multiplied by 40 and divided by a 20 ns clock period, rounding up. The same source therefore serves both the high-performance and the low-power flavour of the tile. Several tiles can receive the same input vector and different weight slices.

Top module: `pim_mac_unit`

## Requirements
- R1: After reset, `busy`, `done` and `rd_valid` are low.
- R2: A buffer read issued while idle returns the last word written to that address. `rd_valid` is high for exactly one cycle, in the first cycle after `busy` falls.
- R3: While idle, each host command holds `busy` high for a fixed number of cycles. A weight write takes the weight-write count and a buffer access takes the buffer count. Fast timing (FAST=1) uses 5/13/1/10 cycles for weight read, weight write, buffer access and multiply-accumulate. Slow timing uses 7/15/2/15.
- R4: A job with base B, length J and C channels works on this layout. Weight i of channel k sits at weight address B+k*J+i. Input i sits at buffer word i, and its low 16 bits are a signed operand. Result k is written to buffer word 48+k, where 48 is three quarters of the buffer depth. Each result is the sum over i of input(i) times weight(k,i).
- R5: A job keeps `busy` high for C*(3 + J*(Rw + 2*Rb + Rm) + Rb) + 2 cycles, where Rw, Rb and Rm are the weight-read, buffer and multiply-accumulate counts.
- R6: The accumulator is 32 bits wide, wraps modulo 2^32, and is cleared at the start of every channel.
- R7: `done` is high for exactly one cycle per job, in the last cycle that `busy` is high, after the last result has been written.
- R8: A start received while the tile is busy is ignored. The running job keeps its length and its result count, and no second job follows.
- R9: When several commands arrive together while idle, the tile accepts exactly one of them. Start wins over weight write, weight write wins over buffer write, and buffer write wins over buffer read. The others are dropped.
- R10: A job with C=0 lasts 2 cycles and writes nothing. A job with J=0 writes 0 to each of its C results.
- R11: After a job with C greater than 0, buffer words 32+i hold the sign-extended weights of the last channel. 32 is half the buffer depth.
- R12: A job never writes the input region (buffer words below 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_we | input | 1 | Weight-store write command |
| wt_addr | input | WT_AW | Weight-store write address |
| wt_data | input | 16 | Weight to store |
| buf_we | input | 1 | Buffer write command |
| buf_re | input | 1 | Buffer read command |
| buf_addr | input | BUF_AW | Buffer address for host read or write |
| buf_wdata | input | 32 | Buffer write word |
| start | input | 1 | Job start command |
| job_base | input | WT_AW | First weight address of the job |
| job_len | input | BUF_AW-1 | Input vector length J (0 to 16) |
| job_chans | input | BUF_AW-1 | Number of output channels C (0 to 16) |
| busy | output | 1 | Tile is executing a command or job |
| done | output | 1 | One-cycle pulse at the end of a job |
| rd_data | output | 32 | Buffer read result |
| rd_valid | output | 1 | One-cycle pulse qualifying `rd_data` |

## Verification
Two collisions matter most. The first is a start arriving in the same cycle as a weight write and a buffer write. The bench raises all three at one edge and then runs the job. It judges the result by reading back the buffer word that was not overwritten and by checking that the job output still uses the old weight. A second collision pits a weight write against a buffer write: the busy time must match the weight-write count, and the buffer word must be unchanged. A start is also pulsed in the middle of a running job. The bench then checks that the busy length matches the job's own formula and that exactly one done pulse appears.

// File: rtl/pim_pkg.sv
package pim_pkg;

    localparam int OPW    = 16;
    localparam int ACCW   = 32;
    localparam int CLK_PS = 20000;
    localparam int SCALE  = 40;

    typedef struct packed {
        logic [7:0] wrd;
        logic [7:0] wwr;
        logic [7:0] bacc;
        logic [7:0] mac;
    } lat_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HWT, ST_HBW, ST_HBR,
        ST_CH, ST_CRD, ST_CWR, ST_MRD, ST_MAC, ST_OWR, ST_DONE
    } st_e;

    // Device latency (ps) scaled and rounded up to whole clock cycles
    function automatic logic [7:0] to_cycles(input int ps);
        return 8'((ps * SCALE + CLK_PS - 1) / CLK_PS);
    endfunction

    function automatic lat_t lat_for(input bit fast);
        lat_t l;
        if (fast) begin
            l.wrd  = to_cycles(2270);
            l.wwr  = to_cycles(6170);
            l.bacc = to_cycles(460);
            l.mac  = to_cycles(4720);
        end else begin
            l.wrd  = to_cycles(3440);
            l.wwr  = to_cycles(7160);
            l.bacc = to_cycles(890);
            l.mac  = to_cycles(7420);
        end
        return l;
    endfunction

endpackage

// File: rtl/pim_ram.sv
module pim_ram #(
    parameter int W   = 32,
    parameter int AW  = 6,
    parameter int NRD = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rdata[g] = mem[raddr[g]];
        end
    endgenerate
endmodule

// File: rtl/pim_mac_pe.sv
module pim_mac_pe
    import pim_pkg::*;
#(
    parameter int DW = OPW,
    parameter int AW = ACCW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          fire,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] w,
    output logic [AW-1:0] acc
);
    logic signed [2*DW-1:0] prod;
    assign prod = $signed(x) * $signed(w);

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (fire)  acc <= acc + AW'(prod);
    end

    assert_mac_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(clr && fire));
endmodule

// File: rtl/pim_ctrl.sv
module pim_ctrl
    import pim_pkg::*;
#(
    parameter bit FAST   = 1'b1,
    parameter int WT_AW  = 8,
    parameter int BUF_AW = 6,
    parameter int LEN_W  = BUF_AW - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wt_we_i,
    input  logic [WT_AW-1:0]    wt_addr_i,
    input  logic [OPW-1:0]      wt_data_i,
    input  logic                buf_we_i,
    input  logic                buf_re_i,
    input  logic [BUF_AW-1:0]   buf_addr_i,
    input  logic [ACCW-1:0]     buf_wdata_i,
    input  logic                start_i,
    input  logic [WT_AW-1:0]    base_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [LEN_W-1:0]    chans_i,
    output logic                ws_we_o,
    output logic [WT_AW-1:0]    ws_waddr_o,
    output logic [OPW-1:0]      ws_wdata_o,
    output logic [WT_AW-1:0]    ws_raddr_o,
    input  logic [OPW-1:0]      ws_rdata_i,
    output logic                sb_we_o,
    output logic [BUF_AW-1:0]   sb_waddr_o,
    output logic [ACCW-1:0]     sb_wdata_o,
    output logic [BUF_AW-1:0]   sb_ra0_o,
    output logic [BUF_AW-1:0]   sb_ra1_o,
    input  logic [ACCW-1:0]     sb_rd0_i,
    input  logic [ACCW-1:0]     sb_rd1_i,
    output logic                mac_clr_o,
    output logic                mac_fire_o,
    output logic [OPW-1:0]      mac_x_o,
    output logic [OPW-1:0]      mac_w_o,
    input  logic [ACCW-1:0]     acc_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [ACCW-1:0]     rdata_o,
    output logic                rvalid_o
);
    localparam lat_t LAT = lat_for(FAST);
    localparam logic [BUF_AW-1:0] STG_BASE = BUF_AW'(1 << (BUF_AW - 1));
    localparam logic [BUF_AW-1:0] OUT_BASE = BUF_AW'(3 << (BUF_AW - 2));

    st_e                state;
    logic [7:0]         cnt, cur_lat;
    logic               last;
    logic [LEN_W-1:0]   i_q, len_q, k_q, left_q;
    logic [WT_AW-1:0]   wptr_q, hw_addr_q;
    logic [OPW-1:0]     hw_data_q, tmp_q, x_q, w_q;
    logic [BUF_AW-1:0]  hb_addr_q;
    logic [ACCW-1:0]    hb_data_q, rdata_q;
    logic               rvalid_q;

    always_comb begin
        case (state)
            ST_HWT:                                    cur_lat = LAT.wwr;
            ST_CRD:                                    cur_lat = LAT.wrd;
            ST_MAC:                                    cur_lat = LAT.mac;
            ST_HBW, ST_HBR, ST_CWR, ST_MRD, ST_OWR:    cur_lat = LAT.bacc;
            default:                                   cur_lat = 8'd1;
        endcase
    end
    assign last = (cnt == cur_lat - 8'd1);

    always_comb begin
        case (state)
            ST_CWR: begin
                sb_waddr_o = STG_BASE + BUF_AW'(i_q);
                sb_wdata_o = ACCW'($signed(tmp_q));
            end
            ST_OWR: begin
                sb_waddr_o = OUT_BASE + BUF_AW'(k_q);
                sb_wdata_o = acc_i;
            end
            default: begin
                sb_waddr_o = hb_addr_q;
                sb_wdata_o = hb_data_q;
            end
        endcase
    end

    assign sb_we_o    = last && (state == ST_HBW || state == ST_CWR || state == ST_OWR);
    assign sb_ra0_o   = (state == ST_HBR) ? hb_addr_q : BUF_AW'(i_q);
    assign sb_ra1_o   = STG_BASE + BUF_AW'(i_q);
    assign ws_we_o    = (state == ST_HWT) && last;
    assign ws_waddr_o = hw_addr_q;
    assign ws_wdata_o = hw_data_q;
    assign ws_raddr_o = wptr_q;
    assign mac_clr_o  = (state == ST_CH);
    assign mac_fire_o = (state == ST_MAC) && last;
    assign mac_x_o    = x_q;
    assign mac_w_o    = w_q;
    assign busy_o     = (state != ST_IDLE);
    assign done_o     = (state == ST_DONE);
    assign rdata_o    = rdata_q;
    assign rvalid_o   = rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            i_q       <= '0;
            len_q     <= '0;
            k_q       <= '0;
            left_q    <= '0;
            wptr_q    <= '0;
            hw_addr_q <= '0;
            hw_data_q <= '0;
            tmp_q     <= '0;
            x_q       <= '0;
            w_q       <= '0;
            hb_addr_q <= '0;
            hb_data_q <= '0;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            cnt      <= cnt + 8'd1;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_i) begin
                        left_q <= chans_i;
                        len_q  <= len_i;
                        k_q    <= '0;
                        wptr_q <= base_i;
                        state  <= ST_CH;
                    end else if (wt_we_i) begin
                        hw_addr_q <= wt_addr_i;
                        hw_data_q <= wt_data_i;
                        state     <= ST_HWT;
                    end else if (buf_we_i) begin
                        hb_addr_q <= buf_addr_i;
                        hb_data_q <= buf_wdata_i;
                        state     <= ST_HBW;
                    end else if (buf_re_i) begin
                        hb_addr_q <= buf_addr_i;
                        state     <= ST_HBR;
                    end
                end
                ST_HWT, ST_HBW: if (last) state <= ST_IDLE;
                ST_HBR: if (last) begin
                    rdata_q  <= sb_rd0_i;
                    rvalid_q <= 1'b1;
                    state    <= ST_IDLE;
                end
                ST_CH: begin
                    cnt   <= '0;
                    i_q   <= '0;
                    state <= (left_q == '0) ? ST_DONE : ST_CRD;
                end
                ST_CRD: begin
                    if (i_q == len_q) begin
                        i_q   <= '0;
                        cnt   <= '0;
                        state <= ST_MRD;
                    end else if (last) begin
                        tmp_q <= ws_rdata_i;
                        cnt   <= '0;
                        state <= ST_CWR;
                    end
                end
                ST_CWR: if (last) begin
                    i_q    <= i_q + 1'b1;
                    wptr_q <= wptr_q + 1'b1;
                    cnt    <= '0;
                    state  <= ST_CRD;
                end
                ST_MRD: begin
                    if (i_q == len_q) begin
                        cnt   <= '0;
                        state <= ST_OWR;
                    end else if (last) begin
                        x_q   <= sb_rd0_i[OPW-1:0];
                        w_q   <= sb_rd1_i[OPW-1:0];
                        cnt   <= '0;
                        state <= ST_MAC;
                    end
                end
                ST_MAC: if (last) begin
                    i_q   <= i_q + 1'b1;
                    cnt   <= '0;
                    state <= ST_MRD;
                end
                ST_OWR: if (last) begin
                    k_q    <= k_q + 1'b1;
                    left_q <= left_q - 1'b1;
                    cnt    <= '0;
                    state  <= ST_CH;
                end
                ST_DONE: begin
                    cnt   <= '0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (left_q <= $past(left_q)));

    assert_rvalid_src_R2: assert property (@(posedge clk) disable iff (rst)
        rvalid_q |-> ($past(state) == ST_HBR));

    assert_wait_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (cnt < cur_lat));

    assert_input_safe_R12: assert property (@(posedge clk) disable iff (rst)
        (sb_we_o && state != ST_HBW) |-> (sb_waddr_o >= STG_BASE));
endmodule

// File: rtl/pim_mac_unit.sv
module pim_mac_unit
    import pim_pkg::*;
#(
    parameter bit FAST   = 1'b1,
    parameter int WT_AW  = 8,
    parameter int BUF_AW = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wt_we,
    input  logic [WT_AW-1:0]     wt_addr,
    input  logic [15:0]          wt_data,
    input  logic                 buf_we,
    input  logic                 buf_re,
    input  logic [BUF_AW-1:0]    buf_addr,
    input  logic [31:0]          buf_wdata,
    input  logic                 start,
    input  logic [WT_AW-1:0]     job_base,
    input  logic [BUF_AW-2:0]    job_len,
    input  logic [BUF_AW-2:0]    job_chans,
    output logic                 busy,
    output logic                 done,
    output logic [31:0]          rd_data,
    output logic                 rd_valid
);
    localparam int LEN_W = BUF_AW - 1;

    logic                          ws_we;
    logic [WT_AW-1:0]              ws_waddr;
    logic [OPW-1:0]                ws_wdata;
    logic [0:0][WT_AW-1:0]         ws_raddr;
    logic [0:0][OPW-1:0]           ws_rdata;
    logic                          sb_we;
    logic [BUF_AW-1:0]             sb_waddr;
    logic [ACCW-1:0]               sb_wdata;
    logic [1:0][BUF_AW-1:0]        sb_raddr;
    logic [1:0][ACCW-1:0]          sb_rdata;
    logic                          mac_clr, mac_fire;
    logic [OPW-1:0]                mac_x, mac_w;
    logic [ACCW-1:0]               acc;

    pim_ctrl #(.FAST(FAST), .WT_AW(WT_AW), .BUF_AW(BUF_AW), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wt_we_i    (wt_we),
        .wt_addr_i  (wt_addr),
        .wt_data_i  (wt_data),
        .buf_we_i   (buf_we),
        .buf_re_i   (buf_re),
        .buf_addr_i (buf_addr),
        .buf_wdata_i(buf_wdata),
        .start_i    (start),
        .base_i     (job_base),
        .len_i      (job_len),
        .chans_i    (job_chans),
        .ws_we_o    (ws_we),
        .ws_waddr_o (ws_waddr),
        .ws_wdata_o (ws_wdata),
        .ws_raddr_o (ws_raddr[0]),
        .ws_rdata_i (ws_rdata[0]),
        .sb_we_o    (sb_we),
        .sb_waddr_o (sb_waddr),
        .sb_wdata_o (sb_wdata),
        .sb_ra0_o   (sb_raddr[0]),
        .sb_ra1_o   (sb_raddr[1]),
        .sb_rd0_i   (sb_rdata[0]),
        .sb_rd1_i   (sb_rdata[1]),
        .mac_clr_o  (mac_clr),
        .mac_fire_o (mac_fire),
        .mac_x_o    (mac_x),
        .mac_w_o    (mac_w),
        .acc_i      (acc),
        .busy_o     (busy),
        .done_o     (done),
        .rdata_o    (rd_data),
        .rvalid_o   (rd_valid)
    );

    pim_ram #(.W(OPW), .AW(WT_AW), .NRD(1)) u_wstore (
        .clk  (clk),
        .we   (ws_we),
        .waddr(ws_waddr),
        .wdata(ws_wdata),
        .raddr(ws_raddr),
        .rdata(ws_rdata)
    );

    pim_ram #(.W(ACCW), .AW(BUF_AW), .NRD(2)) u_sbuf (
        .clk  (clk),
        .we   (sb_we),
        .waddr(sb_waddr),
        .wdata(sb_wdata),
        .raddr(sb_raddr),
        .rdata(sb_rdata)
    );

    pim_mac_pe #(.DW(OPW), .AW(ACCW)) u_pe (
        .clk (clk),
        .rst (rst),
        .clr (mac_clr),
        .fire(mac_fire),
        .x   (mac_x),
        .w   (mac_w),
        .acc (acc)
    );

    assert_idle_reply_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !busy);
endmodule

// File: tb/pim_mac_unit_tb.sv
`timescale 1ns/1ps
module pim_mac_unit_tb;
    localparam int STG = 32, OUTB = 48;
    localparam int HR = 5, HW = 13, HB = 1, HM = 10;
    localparam int LR = 7, LW = 15, LB = 2, LM = 15;
    localparam int NV = 5;
    localparam int TJ [NV] = '{4, 16, 1, 7, 16};
    localparam int TC [NV] = '{2, 3, 16, 5, 16};
    localparam int TB [NV] = '{0, 10, 100, 37, 0};
    localparam int TS [NV] = '{1, 2, 3, 4, 5};

    logic clk = 1'b0, rst = 1'b1;
    logic wt_we = 0, lp_wt_we = 0, buf_we = 0, lp_buf_we = 0, buf_re = 0, lp_buf_re = 0;
    logic start = 0, lp_start = 0;
    logic [7:0]  waddr = 0, cfg_base = 0;
    logic [15:0] wdata = 0;
    logic [5:0]  baddr = 0;
    logic [31:0] bdata = 0;
    logic [4:0]  cfg_len = 0, cfg_ch = 0;
    logic busy, done, rvalid, lp_busy, lp_done, lp_rvalid;
    logic [31:0] rdata, lp_rdata;

    int errors = 0, total = 0, cyc = 0;
    logic signed [15:0] wm [256];
    logic [31:0] bm [64];

    always #4 clk = ~clk;

    pim_mac_unit #(.FAST(1'b1)) u_dut (
        .clk(clk), .rst(rst), .wt_we(wt_we), .wt_addr(waddr), .wt_data(wdata),
        .buf_we(buf_we), .buf_re(buf_re), .buf_addr(baddr), .buf_wdata(bdata),
        .start(start), .job_base(cfg_base), .job_len(cfg_len), .job_chans(cfg_ch),
        .busy(busy), .done(done), .rd_data(rdata), .rd_valid(rvalid));

    pim_mac_unit #(.FAST(1'b0)) u_lp (
        .clk(clk), .rst(rst), .wt_we(lp_wt_we), .wt_addr(waddr), .wt_data(wdata),
        .buf_we(lp_buf_we), .buf_re(lp_buf_re), .buf_addr(baddr), .buf_wdata(bdata),
        .start(lp_start), .job_base(cfg_base), .job_len(cfg_len), .job_chans(cfg_ch),
        .busy(lp_busy), .done(lp_done), .rd_data(lp_rdata), .rd_valid(lp_rvalid));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; total++;
            $display("FAIL R5 watchdog: actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    function automatic logic [15:0] gen(int s, int n);
        return 16'(s * 40503 + n * 7919 + n * n * 13 + 1);
    endfunction

    function automatic logic [31:0] sx(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle(input bit lp, output int dur);
        dur = 0;
        while (lp ? lp_busy : busy) begin
            dur++;
            @(negedge clk);
        end
    endtask

    task automatic host_wt(input bit lp, input int a, input logic [15:0] v, output int dur);
        @(negedge clk);
        waddr = 8'(a); wdata = v;
        if (lp) lp_wt_we = 1; else wt_we = 1;
        @(negedge clk);
        wt_we = 0; lp_wt_we = 0;
        wait_idle(lp, dur);
    endtask

    task automatic host_bw(input bit lp, input int a, input logic [31:0] v, output int dur);
        @(negedge clk);
        baddr = 6'(a); bdata = v;
        if (lp) lp_buf_we = 1; else buf_we = 1;
        @(negedge clk);
        buf_we = 0; lp_buf_we = 0;
        wait_idle(lp, dur);
    endtask

    task automatic host_br(input bit lp, input int a, output logic [31:0] v, output int dur, output bit vok);
        @(negedge clk);
        baddr = 6'(a);
        if (lp) lp_buf_re = 1; else buf_re = 1;
        @(negedge clk);
        buf_re = 0; lp_buf_re = 0;
        wait_idle(lp, dur);
        vok = lp ? lp_rvalid : rvalid;
        v = lp ? lp_rdata : rdata;
        @(negedge clk);
        if (lp ? lp_rvalid : rvalid) vok = 0;
    endtask

    task automatic ld_w(input int a, input logic [15:0] v);
        int d;
        host_wt(0, a, v, d);
        wm[a] = v;
    endtask

    task automatic ld_b(input int a, input logic [31:0] v);
        int d;
        host_bw(0, a, v, d);
        bm[a] = v;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        int d; bit ok; logic [31:0] v;
        host_br(0, a, v, d, ok);
        chk(req, $sformatf("buffer word %0d", a), v, exp);
    endtask

    task automatic run_job(input bit lp, input int base, input int j, input int c, input int poke,
                           output int dur, output int dones, output bit dlast);
        @(negedge clk);
        cfg_base = 8'(base); cfg_len = 5'(j); cfg_ch = 5'(c);
        if (lp) lp_start = 1; else start = 1;
        @(negedge clk);
        start = 0; lp_start = 0;
        dur = 0; dones = 0; dlast = 0;
        while (lp ? lp_busy : busy) begin
            dur++;
            dlast = (lp ? lp_done : done);
            if (dlast) dones++;
            if (dur == poke) begin
                cfg_ch = 5'd16; cfg_len = 5'd16;
                start = 1;
            end
            @(negedge clk);
            start = 0;
        end
    endtask

    function automatic logic [31:0] exp_out(int base, int j, int k);
        logic signed [31:0] s, p;
        s = 0;
        for (int i = 0; i < j; i++) begin
            p = $signed(bm[i][15:0]) * $signed(wm[base + k * j + i]);
            s = s + p;
        end
        return s;
    endfunction

    task automatic job_and_check(input string tag, input int base, input int j, input int c, input int poke);
        int dur, dn; bit dl;
        logic [31:0] eo [16];
        for (int k = 0; k < c; k++) eo[k] = exp_out(base, j, k);
        run_job(0, base, j, c, poke, dur, dn, dl);
        chk("R5", {tag, " duration"}, 32'(dur), 32'(c * (3 + j * (HR + 2 * HB + HM) + HB) + 2));
        chk("R7", {tag, " done count"}, 32'(dn), 1);
        chk("R7", {tag, " done on last busy cycle"}, {31'd0, dl}, 1);
        for (int k = 0; k < c; k++) begin
            bm[OUTB + k] = eo[k];
            rd_chk("R4", OUTB + k, eo[k]);
        end
        if (c > 0)
            for (int i = 0; i < j; i++) rd_chk("R11", STG + i, sx(wm[base + (c - 1) * j + i]));
        if (j > 0) rd_chk("R12", j - 1, bm[j - 1]);
    endtask

    initial begin
        int d, dn; bit ok, dl; logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1", "busy after reset", {31'd0, busy}, 0);
        chk("R1", "done after reset", {31'd0, done}, 0);
        chk("R1", "rd_valid after reset", {31'd0, rvalid}, 0);
        chk("R1", "slow busy after reset", {31'd0, lp_busy}, 0);
        rst = 0;
        @(negedge clk);

        // R3 / R2: host access timing, fast and slow
        host_wt(0, 0, 16'h0003, d);      wm[0] = 16'h0003;
        chk("R3", "fast weight write cycles", 32'(d), HW);
        host_bw(0, 9, 32'hCAFE_0001, d); bm[9] = 32'hCAFE_0001;
        chk("R3", "fast buffer write cycles", 32'(d), HB);
        host_br(0, 9, v, d, ok);
        chk("R3", "fast buffer read cycles", 32'(d), HB);
        chk("R2", "read data", v, 32'hCAFE_0001);
        chk("R2", "rd_valid single pulse after busy", {31'd0, ok}, 1);
        host_wt(1, 0, 16'h0003, d);
        chk("R3", "slow weight write cycles", 32'(d), LW);
        host_wt(1, 1, 16'hFFFB, d);
        host_bw(1, 0, 32'd7, d);
        chk("R3", "slow buffer write cycles", 32'(d), LB);
        host_bw(1, 1, 32'd2, d);
        host_br(1, 1, v, d, ok);
        chk("R3", "slow buffer read cycles", 32'(d), LB);
        chk("R2", "slow read data", v, 32'd2);
        run_job(1, 0, 2, 1, 0, d, dn, dl);
        chk("R5", "slow job duration", 32'(d), 32'(1 * (3 + 2 * (LR + 2 * LB + LM) + LB) + 2));
        host_br(1, OUTB, v, d, ok);
        chk("R4", "slow job result", v, 32'd11);

        // Vector table of jobs
        for (int t = 0; t < NV; t++) begin
            for (int i = 0; i < TJ[t]; i++) ld_b(i, sx(gen(TS[t], i)));
            for (int n = 0; n < TJ[t] * TC[t]; n++) ld_w(TB[t] + n, gen(TS[t] + 50, n));
            job_and_check($sformatf("vector %0d", t), TB[t], TJ[t], TC[t], 0);
        end

        // R6: wrap-around and per-channel clear
        for (int i = 0; i < 4; i++) ld_b(i, 32'hFFFF_8000);
        for (int i = 0; i < 4; i++) ld_w(i, 16'h8000);
        for (int i = 4; i < 8; i++) ld_w(i, 16'h0001);
        job_and_check("R6 wrap", 0, 4, 2, 0);
        rd_chk("R6", OUTB, 32'h0000_0000);
        rd_chk("R6", OUTB + 1, 32'hFFFE_0000);

        // R8: start pulsed while busy
        job_and_check("R8 restart", 0, 4, 2, 10);
        repeat (3) begin
            @(negedge clk);
            chk("R8", "busy stays low after job", {31'd0, busy}, 0);
        end

        // R10: empty jobs
        ld_b(OUTB, 32'hDEAD_BEEF);
        run_job(0, 0, 3, 0, 0, d, dn, dl);
        chk("R10", "zero-channel duration", 32'(d), 2);
        chk("R10", "zero-channel done", 32'(dn), 1);
        rd_chk("R10", OUTB, 32'hDEAD_BEEF);
        ld_b(OUTB + 1, 32'h1111_2222);
        run_job(0, 0, 0, 2, 0, d, dn, dl);
        chk("R10", "zero-length duration", 32'(d), 2 * (3 + HB) + 2);
        rd_chk("R10", OUTB, 0);
        rd_chk("R10", OUTB + 1, 0);

        // R9: simultaneous commands
        ld_b(5, 32'h0000_1234);
        ld_b(0, 32'h0000_0006);
        ld_w(0, 16'h0004);
        @(negedge clk);
        cfg_base = 0; cfg_len = 1; cfg_ch = 1;
        start = 1; buf_we = 1; wt_we = 1;
        baddr = 5; bdata = 32'hAAAA_AAAA; waddr = 0; wdata = 16'h0007;
        @(negedge clk);
        start = 0; buf_we = 0; wt_we = 0;
        wait_idle(0, d);
        chk("R9", "start wins duration", 32'(d), 1 * (3 + 1 * (HR + 2 * HB + HM) + HB) + 2);
        rd_chk("R9", OUTB, 32'd24);
        rd_chk("R9", 5, 32'h0000_1234);
        @(negedge clk);
        buf_we = 1; wt_we = 1; baddr = 5; bdata = 32'hBBBB_BBBB; waddr = 0; wdata = 16'h0007;
        @(negedge clk);
        buf_we = 0; wt_we = 0;
        wait_idle(0, d);
        wm[0] = 16'h0007;
        chk("R9", "weight write wins duration", 32'(d), HW);
        rd_chk("R9", 5, 32'h0000_1234);
        job_and_check("R9 new weight", 0, 1, 1, 0);
        rd_chk("R9", OUTB, 32'd42);

        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule